// File: doc/BRIEF.md
# Vertical-First Element Step Controller

This block keeps the element position of a scalar core that walks through vectors one element at a time. It holds a vector length and two element steps, one for sources and one for destinations. It turns each architectural operand number into a physical register index. An operand tagged as vector has the current step added to its base number. An operand tagged as scalar keeps its base number. Ordinary operations only read the steps. The steps move only when the decoder raises an explicit step command.

The step command can also report, through a condition flag, that the loop has reached the vector length. Software can then close the loop with an ordinary conditional branch. A loop counter sits beside the steps. It counts the elements stepped since the last branch decrement. On a branch-side request it is reduced by that element count rather than by one.

Top module: `vf_step_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both steps, the vector length, the loop counter, the element tally, the condition flag and its write strobe to zero.
- R2: A length write sets the vector length to the written value, clamped to the maximum of 64. It clears both steps and the element tally on the same edge. A step command in the same cycle as a length write has no effect on any state.
- R3: A step command raises both steps by one on the next rising edge. In any cycle without a step command or a length write, both steps keep their values.
- R4: When a step command brings the incremented step to equal the vector length, both steps return to zero on that edge. The hit condition is true for that command, so the steps never reach the vector length.
- R5: A step command with its record bit at 1 raises the condition write strobe for the following cycle. It loads the condition flag with 1 on a hit and with 0 otherwise.
- R6: A step command with its record bit at 0, or any cycle without a step command, leaves the condition flag unchanged and the write strobe at 0 after the edge.
- R7: The vector tag is 1 for vector and 0 for scalar. A vector-tagged operand resolves, in the same cycle, to base plus dststep for the destination and to base plus srcstep for each source. A scalar-tagged operand resolves to its base. Each operand carries its own tag.
- R8: When a vector-tagged sum exceeds the last register index (127), that operand's out-of-range flag is 1 and its index output is 0 instead of a wrapped value.
- R9: A counter load writes the loop counter on the next edge. It takes priority over a branch decrement in the same cycle, and that decrement is then ignored.
- R10: A branch decrement subtracts the element tally, stopping at zero. The element tally is the number of accepted steps since the last decrement, length write or reset. After the decrement the tally becomes 1 if a step is accepted in the same cycle, and 0 otherwise.
- R11: While the vector length is 0, a step command leaves the steps and the element tally at zero and counts as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vl_wr_en | input | 1 | Vector length write |
| vl_wr_data | input | 7 | New vector length |
| step_cmd | input | 1 | Explicit step command |
| step_rc | input | 1 | Record bit of the step command |
| ctr_load | input | 1 | Loop counter load |
| ctr_load_val | input | 16 | Loop counter load value |
| br_dec | input | 1 | Branch-side decrement request |
| dst_base | input | 7 | Destination base register number |
| dst_vec | input | 1 | Destination vector tag |
| src_base | input | 14 | Source base numbers, source k in bits 7k+6:7k |
| src_vec | input | 2 | Source vector tags, one bit per source |
| dst_idx | output | 7 | Resolved destination index |
| dst_oor | output | 1 | Destination out of range |
| src_idx | output | 14 | Resolved source indices, packed like src_base |
| src_oor | output | 2 | Source out-of-range flags |
| srcstep | output | 6 | Current source step |
| dststep | output | 6 | Current destination step |
| vl_cur | output | 7 | Current vector length |
| cr_eq | output | 1 | Condition flag (length reached) |
| cr_we | output | 1 | Condition flag write strobe |
| ctr_val | output | 16 | Loop counter value |

## Verification
Register indices and out-of-range flags are combinational. The bench compares them one nanosecond after it drives the operands, against the steps registered before that cycle. Steps, length, counter, condition flag and strobe all update one edge after the command. Each command pushes its expected post-edge values into a queue. A monitor pops one entry five nanoseconds after the next rising edge, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/vf_step_pkg.sv
package vf_step_pkg;

  localparam int unsigned DEF_NUM_REGS = 128;
  localparam int unsigned DEF_MAX_VL   = 64;
  localparam int unsigned DEF_NUM_SRC  = 2;
  localparam int unsigned DEF_CTR_W    = 16;

  typedef enum logic {
    OPK_SCALAR = 1'b0,
    OPK_VECTOR = 1'b1
  } opk_e;

  typedef enum logic [1:0] {
    SA_IDLE  = 2'd0,
    SA_ADV   = 2'd1,
    SA_WRAP  = 2'd2,
    SA_EMPTY = 2'd3
  } step_act_e;

endpackage

// File: rtl/vf_operand_map.sv
module vf_operand_map
  import vf_step_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned STEP_W   = 6
) (
  input  logic [$clog2(NUM_REGS)-1:0] base,
  input  opk_e                        kind,
  input  logic [STEP_W-1:0]           step,
  output logic [$clog2(NUM_REGS)-1:0] idx,
  output logic                        oor
);

  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam int unsigned SUM_W = ((IDX_W > STEP_W) ? IDX_W : STEP_W) + 1;
  localparam logic [SUM_W-1:0] LAST_REG = SUM_W'(NUM_REGS - 1);

  // Widened sum so that a carry past the last register is visible.
  function automatic logic [SUM_W-1:0] add_step(
    input logic [IDX_W-1:0]  b,
    input logic [STEP_W-1:0] s
  );
    return SUM_W'(b) + SUM_W'(s);
  endfunction

  logic [SUM_W-1:0] sum_w;
  logic             over_w;

  always_comb begin
    sum_w  = add_step(base, step);
    over_w = (kind == OPK_VECTOR) && (sum_w > LAST_REG);
    if (kind == OPK_SCALAR) begin
      idx = base;
    end else if (over_w) begin
      idx = '0;
    end else begin
      idx = sum_w[IDX_W-1:0];
    end
    oor = over_w;
  end

endmodule

// File: rtl/vf_step_counter.sv
module vf_step_counter
  import vf_step_pkg::*;
#(
  parameter int unsigned MAX_VL = DEF_MAX_VL
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        vl_wr_en,
  input  logic [$clog2(MAX_VL+1)-1:0] vl_wr_data,
  input  logic                        step_cmd,
  input  logic                        step_rc,
  output logic [$clog2(MAX_VL+1)-1:0] vl_q,
  output logic [$clog2(MAX_VL)-1:0]   srcstep_q,
  output logic [$clog2(MAX_VL)-1:0]   dststep_q,
  output logic                        cr_eq_q,
  output logic                        cr_we_q,
  output logic                        elem_tick,
  output logic                        step_hit
);

  localparam int unsigned VL_W   = $clog2(MAX_VL + 1);
  localparam int unsigned STEP_W = $clog2(MAX_VL);
  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  function automatic logic [VL_W-1:0] clamp_vl(input logic [VL_W-1:0] v);
    return (v > VL_CAP) ? VL_CAP : v;
  endfunction

  function automatic step_act_e classify(
    input logic [STEP_W-1:0] cur,
    input logic [VL_W-1:0]   len
  );
    logic [VL_W-1:0] nxt;
    nxt = VL_W'(cur) + VL_W'(1);
    if (len == '0) begin
      return SA_EMPTY;
    end else if (nxt == len) begin
      return SA_WRAP;
    end else begin
      return SA_ADV;
    end
  endfunction

  logic      cmd_live;
  step_act_e act;

  always_comb begin
    cmd_live  = step_cmd && !vl_wr_en;
    act       = cmd_live ? classify(srcstep_q, vl_q) : SA_IDLE;
    step_hit  = (act == SA_WRAP) || (act == SA_EMPTY);
    elem_tick = (act == SA_ADV) || (act == SA_WRAP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q      <= '0;
      srcstep_q <= '0;
      dststep_q <= '0;
    end else if (vl_wr_en) begin
      vl_q      <= clamp_vl(vl_wr_data);
      srcstep_q <= '0;
      dststep_q <= '0;
    end else begin
      unique case (act)
        SA_ADV: begin
          srcstep_q <= srcstep_q + STEP_W'(1);
          dststep_q <= dststep_q + STEP_W'(1);
        end
        SA_WRAP: begin
          srcstep_q <= '0;
          dststep_q <= '0;
        end
        default: begin
          srcstep_q <= srcstep_q;
          dststep_q <= dststep_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_eq_q <= 1'b0;
      cr_we_q <= 1'b0;
    end else begin
      cr_we_q <= cmd_live && step_rc;
      if (cmd_live && step_rc) begin
        cr_eq_q <= step_hit;
      end
    end
  end

endmodule

// File: rtl/vf_loop_ctr.sv
module vf_loop_ctr #(
  parameter int unsigned CTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tally_clr,
  input  logic             elem_tick,
  input  logic             ctr_load,
  input  logic [CTR_W-1:0] ctr_load_val,
  input  logic             br_dec,
  output logic [CTR_W-1:0] ctr_q,
  output logic             dec_fire
);

  localparam logic [CTR_W-1:0] TALLY_MAX = '1;

  function automatic logic [CTR_W-1:0] floor_sub(
    input logic [CTR_W-1:0] a,
    input logic [CTR_W-1:0] b
  );
    return (a > b) ? (a - b) : '0;
  endfunction

  function automatic logic [CTR_W-1:0] sat_inc(input logic [CTR_W-1:0] a);
    return (a == TALLY_MAX) ? a : (a + CTR_W'(1));
  endfunction

  logic [CTR_W-1:0] tally_q;

  always_comb begin
    dec_fire = br_dec && !ctr_load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= '0;
    end else if (ctr_load) begin
      ctr_q <= ctr_load_val;
    end else if (dec_fire) begin
      ctr_q <= floor_sub(ctr_q, tally_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tally_clr) begin
      tally_q <= '0;
    end else if (dec_fire) begin
      tally_q <= elem_tick ? CTR_W'(1) : '0;
    end else if (elem_tick) begin
      tally_q <= sat_inc(tally_q);
    end
  end

endmodule

// File: rtl/vf_step_ctrl.sv
module vf_step_ctrl
  import vf_step_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned MAX_VL   = DEF_MAX_VL,
  parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
  parameter int unsigned CTR_W    = DEF_CTR_W
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                vl_wr_en,
  input  logic [$clog2(MAX_VL+1)-1:0]         vl_wr_data,
  input  logic                                step_cmd,
  input  logic                                step_rc,
  input  logic                                ctr_load,
  input  logic [CTR_W-1:0]                    ctr_load_val,
  input  logic                                br_dec,
  input  logic [$clog2(NUM_REGS)-1:0]         dst_base,
  input  logic                                dst_vec,
  input  logic [NUM_SRC*$clog2(NUM_REGS)-1:0] src_base,
  input  logic [NUM_SRC-1:0]                  src_vec,
  output logic [$clog2(NUM_REGS)-1:0]         dst_idx,
  output logic                                dst_oor,
  output logic [NUM_SRC*$clog2(NUM_REGS)-1:0] src_idx,
  output logic [NUM_SRC-1:0]                  src_oor,
  output logic [$clog2(MAX_VL)-1:0]           srcstep,
  output logic [$clog2(MAX_VL)-1:0]           dststep,
  output logic [$clog2(MAX_VL+1)-1:0]         vl_cur,
  output logic                                cr_eq,
  output logic                                cr_we,
  output logic [CTR_W-1:0]                    ctr_val
);

  localparam int unsigned IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned STEP_W = $clog2(MAX_VL);

  logic elem_tick;
  logic step_hit;
  logic dec_fire;

  vf_step_counter #(
    .MAX_VL (MAX_VL)
  ) u_steps (
    .clk        (clk),
    .rst        (rst),
    .vl_wr_en   (vl_wr_en),
    .vl_wr_data (vl_wr_data),
    .step_cmd   (step_cmd),
    .step_rc    (step_rc),
    .vl_q       (vl_cur),
    .srcstep_q  (srcstep),
    .dststep_q  (dststep),
    .cr_eq_q    (cr_eq),
    .cr_we_q    (cr_we),
    .elem_tick  (elem_tick),
    .step_hit   (step_hit)
  );

  vf_loop_ctr #(
    .CTR_W (CTR_W)
  ) u_loop (
    .clk          (clk),
    .rst          (rst),
    .tally_clr    (vl_wr_en),
    .elem_tick    (elem_tick),
    .ctr_load     (ctr_load),
    .ctr_load_val (ctr_load_val),
    .br_dec       (br_dec),
    .ctr_q        (ctr_val),
    .dec_fire     (dec_fire)
  );

  vf_operand_map #(
    .NUM_REGS (NUM_REGS),
    .STEP_W   (STEP_W)
  ) u_dst_map (
    .base (dst_base),
    .kind (opk_e'(dst_vec)),
    .step (dststep),
    .idx  (dst_idx),
    .oor  (dst_oor)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    vf_operand_map #(
      .NUM_REGS (NUM_REGS),
      .STEP_W   (STEP_W)
    ) u_src_map (
      .base (src_base[k*IDX_W +: IDX_W]),
      .kind (opk_e'(src_vec[k])),
      .step (srcstep),
      .idx  (src_idx[k*IDX_W +: IDX_W]),
      .oor  (src_oor[k])
    );
  end

endmodule

// File: rtl/vf_step_ctrl_chk.sv
module vf_step_ctrl_chk #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned STEP_W = 6,
  parameter int unsigned VL_W   = 7,
  parameter int unsigned CTR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              vl_wr_en,
  input logic              step_cmd,
  input logic              step_rc,
  input logic              ctr_load,
  input logic [CTR_W-1:0]  ctr_load_val,
  input logic [IDX_W-1:0]  dst_base,
  input logic              dst_vec,
  input logic [IDX_W-1:0]  dst_idx,
  input logic              dst_oor,
  input logic [STEP_W-1:0] srcstep,
  input logic [STEP_W-1:0] dststep,
  input logic [VL_W-1:0]   vl_cur,
  input logic              cr_we,
  input logic              cr_eq,
  input logic [CTR_W-1:0]  ctr_val,
  input logic              step_hit,
  input logic              elem_tick
);

  p_vl_clear_r2: assert property (@(posedge clk) disable iff (rst)
    vl_wr_en |=> (srcstep == '0) && (dststep == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!step_cmd && !vl_wr_en) |=> ($stable(srcstep) && $stable(dststep)));

  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (elem_tick && !step_hit) |=> (srcstep == $past(srcstep) + STEP_W'(1)));

  p_below_len_r4: assert property (@(posedge clk) disable iff (rst)
    (vl_cur != '0) |-> (VL_W'(srcstep) < vl_cur));

  p_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (step_cmd && step_rc && !vl_wr_en) |=> (cr_we && (cr_eq == $past(step_hit))));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(step_cmd && step_rc && !vl_wr_en) |=> (!cr_we && $stable(cr_eq)));

  p_scalar_r7: assert property (@(posedge clk) disable iff (rst)
    !dst_vec |-> ((dst_idx == dst_base) && !dst_oor));

  p_oor_zero_r8: assert property (@(posedge clk) disable iff (rst)
    dst_oor |-> (dst_idx == '0));

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    ctr_load |=> (ctr_val == $past(ctr_load_val)));

endmodule

bind vf_step_ctrl vf_step_ctrl_chk #(
  .IDX_W  ($clog2(NUM_REGS)),
  .STEP_W ($clog2(MAX_VL)),
  .VL_W   ($clog2(MAX_VL+1)),
  .CTR_W  (CTR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .vl_wr_en     (vl_wr_en),
  .step_cmd     (step_cmd),
  .step_rc      (step_rc),
  .ctr_load     (ctr_load),
  .ctr_load_val (ctr_load_val),
  .dst_base     (dst_base),
  .dst_vec      (dst_vec),
  .dst_idx      (dst_idx),
  .dst_oor      (dst_oor),
  .srcstep      (srcstep),
  .dststep      (dststep),
  .vl_cur       (vl_cur),
  .cr_we        (cr_we),
  .cr_eq        (cr_eq),
  .ctr_val      (ctr_val),
  .step_hit     (step_hit),
  .elem_tick    (elem_tick)
);

// File: tb/vf_step_ctrl_tb.sv
module vf_step_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vl_wr_en = 1'b0;
  logic [6:0]  vl_wr_data = '0;
  logic        step_cmd = 1'b0;
  logic        step_rc = 1'b0;
  logic        ctr_load = 1'b0;
  logic [15:0] ctr_load_val = '0;
  logic        br_dec = 1'b0;
  logic [6:0]  dst_base = '0;
  logic        dst_vec = 1'b0;
  logic [13:0] src_base = '0;
  logic [1:0]  src_vec = '0;
  logic [6:0]  dst_idx;
  logic        dst_oor;
  logic [13:0] src_idx;
  logic [1:0]  src_oor;
  logic [5:0]  srcstep;
  logic [5:0]  dststep;
  logic [6:0]  vl_cur;
  logic        cr_eq;
  logic        cr_we;
  logic [15:0] ctr_val;

  always #10 clk = ~clk;

  vf_step_ctrl u_dut (
    .clk(clk), .rst(rst), .vl_wr_en(vl_wr_en), .vl_wr_data(vl_wr_data),
    .step_cmd(step_cmd), .step_rc(step_rc), .ctr_load(ctr_load),
    .ctr_load_val(ctr_load_val), .br_dec(br_dec), .dst_base(dst_base),
    .dst_vec(dst_vec), .src_base(src_base), .src_vec(src_vec),
    .dst_idx(dst_idx), .dst_oor(dst_oor), .src_idx(src_idx), .src_oor(src_oor),
    .srcstep(srcstep), .dststep(dststep), .vl_cur(vl_cur), .cr_eq(cr_eq),
    .cr_we(cr_we), .ctr_val(ctr_val)
  );

  typedef struct {
    int    step;
    int    vl;
    int    ctr;
    bit    eq;
    bit    we;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;

  // Bench-side model of the architectural state.
  int m_step = 0, m_vl = 0, m_ctr = 0, m_tally = 0;
  bit m_eq = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: one item per cycle, sampled mid-high.
  always begin
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " srcstep"}, int'(srcstep), e.step);
      check({e.tag, " dststep"}, int'(dststep), e.step);
      check({e.tag, " vl"},      int'(vl_cur),  e.vl);
      check({e.tag, " ctr"},     int'(ctr_val), e.ctr);
      check({e.tag, " cr_eq"},   int'(cr_eq),   int'(e.eq));
      check({e.tag, " cr_we"},   int'(cr_we),   int'(e.we));
    end
  end

  task automatic cyc(input string tag, input bit wr, input int wval,
                     input bit st, input bit rc, input bit ld,
                     input int lval, input bit dec);
    exp_t e;
    bit   acc;
    bit   hit;
    bit   we;
    @(negedge clk);
    vl_wr_en = wr; vl_wr_data = 7'(wval); step_cmd = st; step_rc = rc;
    ctr_load = ld; ctr_load_val = 16'(lval); br_dec = dec;
    acc = 0; hit = 0; we = 0;
    if (!wr && st) begin
      we = rc;
      if (m_vl == 0) hit = 1;
      else begin
        acc = 1;
        hit = (m_step + 1 == m_vl);
      end
    end
    if (ld) m_ctr = lval;
    else if (dec) m_ctr = (m_ctr > m_tally) ? m_ctr - m_tally : 0;
    if (wr) m_tally = 0;
    else if (dec && !ld) m_tally = acc ? 1 : 0;
    else if (acc) m_tally = m_tally + 1;
    if (wr) begin
      m_vl = (wval > 64) ? 64 : wval;
      m_step = 0;
    end else if (acc) begin
      m_step = hit ? 0 : m_step + 1;
    end
    if (we) m_eq = hit;
    e.step = m_step; e.vl = m_vl; e.ctr = m_ctr; e.eq = m_eq; e.we = we;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic int map_exp(input int base, input bit vec, input int st);
    if (!vec) return base;
    return (base + st > 127) ? 0 : base + st;
  endfunction

  task automatic probe(input int db, input bit dv, input int s0, input bit v0,
                       input int s1, input bit v1);
    int pre;
    pre = m_step;
    idle("R3 idle");
    dst_base = 7'(db); dst_vec = dv;
    src_base = {7'(s1), 7'(s0)}; src_vec = {v1, v0};
    #1;
    check("R7 dst_idx", int'(dst_idx), map_exp(db, dv, pre));
    check("R7 src0_idx", int'(src_idx[6:0]), map_exp(s0, v0, pre));
    check("R7 src1_idx", int'(src_idx[13:7]), map_exp(s1, v1, pre));
    check("R8 dst_oor", int'(dst_oor), int'(dv && (db + pre > 127)));
    check("R8 src0_oor", int'(src_oor[0]), int'(v0 && (s0 + pre > 127)));
    check("R8 src1_oor", int'(src_oor[1]), int'(v1 && (s1 + pre > 127)));
  endtask

  bit done = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 srcstep", int'(srcstep), 0);
    check("R1 vl", int'(vl_cur), 0);
    check("R1 ctr", int'(ctr_val), 0);
    check("R1 cr_we", int'(cr_we), 0);
    check("R1 cr_eq", int'(cr_eq), 0);

    // R11: step with zero length is a hit and moves nothing
    cyc("R11 empty step", 0, 0, 1, 1, 0, 0, 0);
    // R2 length write, then R6/R5/R4
    cyc("R2 vl write", 1, 3, 0, 0, 0, 0, 0);
    cyc("R6 step norec", 0, 0, 1, 0, 0, 0, 0);
    cyc("R5 step rec", 0, 0, 1, 1, 0, 0, 0);
    cyc("R4 wrap", 0, 0, 1, 1, 0, 0, 0);
    idle("R3 hold");
    idle("R6 strobe low");
    // R9 load, R10 decrement by tally of 3
    cyc("R9 load", 0, 0, 0, 0, 1, 100, 0);
    cyc("R10 dec", 0, 0, 0, 0, 0, 0, 1);
    cyc("R3 step", 0, 0, 1, 0, 0, 0, 0);
    cyc("R10 dec with step", 0, 0, 1, 0, 0, 0, 1);
    cyc("R10 dec tally one", 0, 0, 0, 0, 0, 0, 1);
    cyc("R9 load beats dec", 0, 0, 1, 0, 1, 2, 1);
    cyc("R10 floor", 0, 0, 1, 0, 0, 0, 0);
    cyc("R10 floor dec", 0, 0, 0, 0, 0, 0, 1);
    // R2 clamp and priority over step
    cyc("R2 clamp", 1, 100, 1, 1, 0, 0, 0);
    cyc("R2 write with step", 1, 10, 1, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R3 walk", 0, 0, 1, 0, 0, 0, 0);
    probe(3, 1, 9, 0, 120, 1);
    probe(125, 1, 123, 1, 127, 0);
    probe(126, 0, 122, 1, 0, 1);
    // Full length 64 boundary
    cyc("R2 vl 64", 1, 64, 0, 0, 0, 0, 0);
    for (int i = 0; i < 63; i++) cyc("R3 long walk", 0, 0, 1, 0, 0, 0, 0);
    probe(64, 1, 65, 1, 0, 0);
    cyc("R4 wrap at 64", 0, 0, 1, 1, 0, 0, 0);
    cyc("R9 load", 0, 0, 0, 0, 1, 1000, 0);
    cyc("R10 dec 64", 0, 0, 0, 0, 0, 0, 1);
    idle("R6 idle");
    idle("R3 idle");
    // R1: reset clears state that is set
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_step = 0; m_vl = 0; m_ctr = 0; m_tally = 0; m_eq = 0;
    check("R1 vl after run", int'(vl_cur), 0);
    check("R1 ctr after run", int'(ctr_val), 0);
    check("R1 cr_eq after run", int'(cr_eq), 0);
    cyc("R1 tally cleared", 0, 0, 0, 0, 1, 50, 0);
    cyc("R1 dec zero tally", 0, 0, 0, 0, 0, 0, 1);
    idle("R3 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule